// File: doc/BRIEF.md
# Multi-format Audio Serial Port

This block is the serial audio port of a stereo codec, acting as a slave to an externally supplied bit clock and word clock. It shifts a stereo pair of 20-bit converter samples out on one serial line and, at the same time, assembles a stereo pair of incoming samples from another serial line. Data on both lines are two's-complement and most significant bit first.

A 2-bit format code picks one of four framings. Each framing sets where the word sits inside each half-frame and which word-clock level marks the left channel. Outgoing data are always left-aligned. Incoming data are right-aligned (16 or 20 bits), left-aligned, or I2S-aligned, depending on the code. The port accepts a 32 fs bit clock, or one of 40 fs or faster, as each format permits. It runs on a fast system clock. The serial clocks are synchronized into that domain and their edges are detected there.

On the parallel side, the block holds the outgoing left and right samples supplied by the converter. It presents each received left/right pair together, with a one-cycle strobe once per frame after the right word is complete. A power-down input holds the serial output at zero.

Top module: `asp_serial_port`

## Requirements
- R1: After reset, `sdto` is 0, `rx_valid` is 0 and `rx_left`/`rx_right` are all zero.
- R2: For format codes 00, 01 and 10, the 20-bit outgoing word of a half-frame is driven MSB first, starting in the first bit slot after the word-clock change. Each bit is updated after a bit-clock falling edge. Slots after the 20th carry 0.
- R3: For format code 11 (I2S), the outgoing MSB is driven in the second bit slot of the half-frame. With a 32 fs bit clock, only bits 19..5 are sent and the low bits are dropped.
- R4: The word clock high selects the left channel for codes 00, 01 and 10. The word clock low selects the left channel for code 11. This holds for both directions.
- R5: Code 00 receives the last 16 bits sampled on bit-clock rising edges before the word-clock change. They are sign-extended to 20 bits, and earlier bits are ignored.
- R6: Code 01 receives the last 20 bits before the word-clock change. Earlier bits are ignored.
- R7: Code 10 receives 20 bits starting in the first bit slot of the half-frame. Later bits are ignored.
- R8: Code 11 receives bits starting in the second bit slot. With a 32 fs bit clock, the 15 received bits fill bits 19..5 and bits 4..0 read as zero.
- R9: `rx_valid` pulses for exactly one system clock after the right word of a frame is complete, and only if a complete left word preceded it. `rx_left`/`rx_right` change only together with that pulse.
- R10: While `adc_pd` is high, `sdto` stays 0.
- R11: `sdto` changes only after a detected bit-clock falling edge or a power-down change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt | input | 2 | Framing select: 00, 01, 10, 11 |
| adc_pd | input | 1 | Converter power-down; forces the serial output to zero |
| sclk | input | 1 | Serial bit clock from the external master |
| lrck | input | 1 | Word (channel) clock from the external master |
| sdti | input | 1 | Serial data in |
| sdto | output | 1 | Serial data out |
| tx_left | input | 20 | Left sample to transmit |
| tx_right | input | 20 | Right sample to transmit |
| rx_left | output | 20 | Received left sample |
| rx_right | output | 20 | Received right sample |
| rx_valid | output | 1 | One-cycle strobe: new received pair available |

## Verification
The bench pads every unused bit slot with ones. A receiver that counts from the wrong end of the half-frame, or keeps the wrong bits, therefore shows corrupted low or high bits. It also drives right-justified 16-bit words with negative values, which exposes missing sign extension as a positive result. The I2S runs at 32 fs and 48 fs check the one-slot offset and the truncation. An off-by-one offset shifts every word by a factor of two, and a design that does not truncate tries to read bits that belong to the other channel. The run with power-down asserted catches any output that leaks data. A mismatched strobe count or channel swap shows up in the scoreboard as a missing, extra or swapped pair.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [1:0] {
        FMT_RJ16 = 2'b00,
        FMT_RJ20 = 2'b01,
        FMT_LJ20 = 2'b10,
        FMT_I2S  = 2'b11
    } asp_fmt_e;

    // Left channel level of the word clock depends on the framing.
    function automatic logic chan_is_left(input asp_fmt_e f, input logic lr);
        return (f == FMT_I2S) ? ~lr : lr;
    endfunction

    // Bit slots between the word-clock change and the MSB.
    function automatic logic msb_delay(input asp_fmt_e f);
        return (f == FMT_I2S);
    endfunction

endpackage

// File: rtl/asp_edge_sync.sv
module asp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic lrck_in,
    input  logic sdti_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic lrck_s,
    output logic sdti_s
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sclk_sh;
        logic [STAGES-1:0] lrck_sh;
        logic [STAGES-1:0] sdti_sh;
        logic              sclk_last;
    } sync_t;

    sync_t st_d, st_q;

    // All three lines run through equal-length chains so they stay aligned.
    always_comb begin
        st_d           = st_q;
        st_d.sclk_sh   = {st_q.sclk_sh[LAST-1:0], sclk_in};
        st_d.lrck_sh   = {st_q.lrck_sh[LAST-1:0], lrck_in};
        st_d.sdti_sh   = {st_q.sdti_sh[LAST-1:0], sdti_in};
        st_d.sclk_last = st_q.sclk_sh[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_rise = st_q.sclk_sh[LAST] & ~st_q.sclk_last;
    assign sclk_fall = ~st_q.sclk_sh[LAST] & st_q.sclk_last;
    assign lrck_s    = st_q.lrck_sh[LAST];
    assign sdti_s    = st_q.sdti_sh[LAST];

endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
#(
    parameter int WORD_W = 20,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asp_fmt_e          fmt,
    input  logic              adc_pd,
    input  logic              fall_ev,
    input  logic              lrck_s,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    output logic              sdto
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] WORD_C  = CNT_W'(WORD_W);

    typedef struct packed {
        logic              lr_prev;
        logic [CNT_W-1:0]  slot;
        logic [WORD_W-1:0] word;
        logic              dout;
    } tx_t;

    tx_t st_d, st_q;
    logic [CNT_W-1:0]  off_c;
    logic [CNT_W-1:0]  pos;
    logic [WORD_W-1:0] aligned;

    always_comb begin
        st_d    = st_q;
        off_c   = CNT_W'(msb_delay(fmt));
        pos     = '0;
        aligned = '0;
        if (fall_ev) begin
            if (lrck_s != st_q.lr_prev) begin
                st_d.lr_prev = lrck_s;
                st_d.slot    = '0;
                st_d.word    = chan_is_left(fmt, lrck_s) ? tx_left : tx_right;
            end else if (st_q.slot != CNT_MAX) begin
                st_d.slot = st_q.slot + 1'b1;
            end
            pos     = st_d.slot - off_c;
            aligned = st_d.word << pos;
            if (st_d.slot >= off_c && pos < WORD_C) st_d.dout = aligned[WORD_W-1];
            else                                    st_d.dout = 1'b0;
        end
        if (adc_pd) st_d.dout = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.slot <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdto = st_q.dout;

    p_pd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adc_pd) |-> !sdto);

    p_hold_between_falls_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fall_ev) && !$past(adc_pd)) |-> (sdto == $past(sdto)));

endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
#(
    parameter int WORD_W  = 20,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asp_fmt_e          fmt,
    input  logic              rise_ev,
    input  logic              lrck_s,
    input  logic              sdti_s,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid
);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [CNT_W-1:0]  WORD_C  = CNT_W'(WORD_W);
    localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};
    localparam int                EXT_W   = WORD_W - SHORT_W;

    typedef struct packed {
        logic              lr_prev;
        logic              armed;
        logic              left_ok;
        logic [CNT_W-1:0]  slot;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] place;
        logic [WORD_W-1:0] stage_l;
        logic [WORD_W-1:0] out_l;
        logic [WORD_W-1:0] out_r;
        logic              valid;
    } rx_t;

    rx_t st_d, st_q;
    logic [CNT_W-1:0]  off_c;
    logic [CNT_W-1:0]  pos;
    logic [WORD_W-1:0] done_w;

    // Word finished at a word-clock change, per framing.
    always_comb begin
        unique case (fmt)
            FMT_RJ16: done_w = {{EXT_W{st_q.shreg[SHORT_W-1]}}, st_q.shreg[SHORT_W-1:0]};
            FMT_RJ20: done_w = st_q.shreg;
            default:  done_w = st_q.place;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        off_c      = CNT_W'(msb_delay(fmt));
        pos        = '0;
        if (rise_ev) begin
            if (lrck_s != st_q.lr_prev) begin
                if (st_q.armed) begin
                    if (chan_is_left(fmt, st_q.lr_prev)) begin
                        st_d.stage_l = done_w;
                        st_d.left_ok = 1'b1;
                    end else if (st_q.left_ok) begin
                        st_d.out_l   = st_q.stage_l;
                        st_d.out_r   = done_w;
                        st_d.valid   = 1'b1;
                        st_d.left_ok = 1'b0;
                    end
                end
                st_d.armed   = 1'b1;
                st_d.lr_prev = lrck_s;
                st_d.slot    = '0;
                st_d.place   = '0;
            end else if (st_q.slot != CNT_MAX) begin
                st_d.slot = st_q.slot + 1'b1;
            end
            st_d.shreg = {st_q.shreg[WORD_W-2:0], sdti_s};
            pos        = st_d.slot - off_c;
            if (st_d.slot >= off_c && pos < WORD_C && sdti_s)
                st_d.place = st_d.place | (TOP_BIT >> pos);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.slot <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_left  = st_q.out_l;
    assign rx_right = st_q.out_r;
    assign rx_valid = st_q.valid;

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_pair_moves_with_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_left != $past(rx_left)) || (rx_right != $past(rx_right))) |-> rx_valid);

endmodule

// File: rtl/asp_serial_port.sv
module asp_serial_port
    import asp_pkg::*;
#(
    parameter int WORD_W      = 20,
    parameter int SHORT_W     = 16,
    parameter int MAX_SLOTS   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt,
    input  logic              adc_pd,
    input  logic              sclk,
    input  logic              lrck,
    input  logic              sdti,
    output logic              sdto,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid
);
    localparam int CNT_W = $clog2(MAX_SLOTS) + 1;

    logic     sclk_rise, sclk_fall, lrck_s, sdti_s;
    asp_fmt_e fmt_e;

    assign fmt_e = asp_fmt_e'(fmt);

    asp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk),
        .lrck_in  (lrck),
        .sdti_in  (sdti),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .lrck_s   (lrck_s),
        .sdti_s   (sdti_s)
    );

    asp_tx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt     (fmt_e),
        .adc_pd  (adc_pd),
        .fall_ev (sclk_fall),
        .lrck_s  (lrck_s),
        .tx_left (tx_left),
        .tx_right(tx_right),
        .sdto    (sdto)
    );

    asp_rx #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt     (fmt_e),
        .rise_ev (sclk_rise),
        .lrck_s  (lrck_s),
        .sdti_s  (sdti_s),
        .rx_left (rx_left),
        .rx_right(rx_right),
        .rx_valid(rx_valid)
    );

    p_strobe_follows_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sclk_rise));

    p_rise_fall_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |-> !$past(sclk_rise));

endmodule

// File: tb/sim_asp_serial_port.sv
module sim_asp_serial_port;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        adc_pd = 1'b0;
    logic        sclk = 1'b0, lrck = 1'b0, sdti = 1'b0;
    logic        sdto;
    logic [19:0] tx_left = '0, tx_right = '0;
    logic [19:0] rx_left, rx_right;
    logic        rx_valid;

    always #10 clk = ~clk;

    asp_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .adc_pd(adc_pd),
        .sclk(sclk), .lrck(lrck), .sdti(sdti), .sdto(sdto),
        .tx_left(tx_left), .tx_right(tx_right),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    int          n_run = 0, n_fail = 0;
    bit          done = 0;
    int          cur_mode = 0;
    bit          cur_pd = 0;
    string       rx_tag = "R5";
    logic [39:0] exp_q[$];

    function automatic logic [19:0] pat(input int n);
        case (n % 7)
            0: return 20'h7FFFF;
            1: return 20'h80000;
            2: return 20'h0A5C3;
            3: return 20'hF8765;
            4: return 20'h1B2D4;
            5: return 20'h08001;
            default: return 20'hCE39A;
        endcase
    endfunction

    function automatic logic tx_bit(input int i, input logic [19:0] w);
        int k = i - ((cur_mode == 3) ? 1 : 0);
        if (cur_pd) return 1'b0;
        if (k >= 0 && k < 20) return w[19-k];
        return 1'b0;
    endfunction

    // Unused slots carry ones so stray capture shows up.
    function automatic logic rx_bit(input int i, input int s, input logic [19:0] w);
        int j = s - 1 - i;
        int k;
        case (cur_mode)
            0: return (j < 16) ? w[j] : 1'b1;
            1: return (j < 20) ? w[j] : 1'b1;
            2: return (i < 20) ? w[19-i] : 1'b1;
            default: begin
                k = i - 1;
                return (k >= 0 && k < 20) ? w[19-k] : 1'b1;
            end
        endcase
    endfunction

    function automatic logic [19:0] rx_word(input int s, input logic [19:0] w);
        int n;
        logic [19:0] m;
        case (cur_mode)
            0: return {{4{w[15]}}, w[15:0]};
            3: begin
                n = (s - 1 < 20) ? s - 1 : 20;
                m = ~(20'hFFFFF >> n);
                return w & m;
            end
            default: return w;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; sclk = 1'b0; lrck = 1'b0; sdti = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_half(input bit left, input int s, input logic [19:0] txw,
                             input logic [19:0] rxw, input bit chk);
        logic lr = (cur_mode == 3) ? ~left : left;
        int   bad = -1;
        logic got_b = 1'b0, exp_b = 1'b0;
        for (int i = 0; i < s; i++) begin
            sclk = 1'b0; lrck = lr; sdti = rx_bit(i, s, rxw);
            repeat (HALF) @(negedge clk);
            if (bad < 0 && sdto !== tx_bit(i, txw)) begin
                bad = i; got_b = sdto; exp_b = tx_bit(i, txw);
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        if (chk) begin
            n_run++;
            if (bad >= 0) begin
                n_fail++;
                $display("FAIL %s/R4 sdto mode %0d slot %0d of %0d: got %b exp %b",
                         cur_pd ? "R10" : (cur_mode == 3 ? "R3" : "R2"),
                         cur_mode, bad, s, got_b, exp_b);
            end
        end
    endtask

    task automatic run_cfg(input int mode, input int s, input bit pd, input int seed);
        cur_mode = mode; cur_pd = pd; adc_pd = pd; fmt = 2'(mode);
        case (mode)
            0: rx_tag = "R5";
            1: rx_tag = "R6";
            2: rx_tag = "R7";
            default: rx_tag = "R8";
        endcase
        do_reset();
        send_half(1'b0, s, 20'h0, 20'h12345, 1'b0);
        for (int f = 0; f < 3; f++) begin
            logic [19:0] tl = pat(seed + 2 * f);
            logic [19:0] tr = pat(seed + 2 * f + 1);
            logic [19:0] rl = pat(seed + 2 * f + 3);
            logic [19:0] rr = pat(seed + 2 * f + 5) ^ 20'h00F0F;
            tx_left = tl; tx_right = tr;
            exp_q.push_back({rx_word(s, rl), rx_word(s, rr)});
            send_half(1'b1, s, tl, rl, 1'b1);
            send_half(1'b0, s, tr, rr, 1'b1);
        end
        send_half(1'b1, s, 20'h0, 20'h0, 1'b0);
        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 mode %0d: %0d pairs never strobed, exp 0", mode, exp_q.size());
            exp_q.delete();
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            logic [39:0] e;
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 extra strobe: got %h_%h exp none", rx_left, rx_right);
            end else begin
                e = exp_q.pop_front();
                if ({rx_left, rx_right} !== e) begin
                    n_fail++;
                    $display("FAIL %s/R4 rx pair mode %0d: got %h_%h exp %h_%h",
                             rx_tag, cur_mode, rx_left, rx_right, e[39:20], e[19:0]);
                end
            end
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        n_run++;
        if (sdto !== 1'b0 || rx_valid !== 1'b0 || rx_left !== '0 || rx_right !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: got sdto=%b v=%b l=%h r=%h exp 0", sdto, rx_valid, rx_left, rx_right);
        end
        run_cfg(0, 16, 1'b0, 0);   // R5 at 32 fs
        run_cfg(0, 32, 1'b0, 1);   // R5 at 64 fs
        run_cfg(1, 20, 1'b0, 2);   // R6 at 40 fs
        run_cfg(1, 32, 1'b0, 3);   // R6 at 64 fs
        run_cfg(2, 20, 1'b0, 4);   // R7 at 40 fs
        run_cfg(2, 32, 1'b0, 5);   // R7 at 64 fs
        run_cfg(3, 16, 1'b0, 6);   // R3 R8 truncation at 32 fs
        run_cfg(3, 24, 1'b0, 0);   // R3 R8 at 48 fs
        run_cfg(3, 32, 1'b0, 1);   // R3 R8 at 64 fs
        run_cfg(2, 32, 1'b1, 2);   // R10 power-down
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule